// File: doc/BRIEF.md
# Biphase Data Line Word Extractor

This block sits behind a data slicer on one television line that carries fifteen 8-bit words. It takes a stream of half-bit samples (two per bit, each marked by a sample-valid strobe) and a line-start strobe. That strobe is raised only for line 16 of the first field. After the strobe the block searches the stream for the start code. From the following bit onward it decodes the biphase stream one bit at a time and counts words.

It keeps only five of those words: 5, 11, 12, 13 and 14. Each kept bit is checked for biphase violations. The block reorders the kept words so that words 11 to 14 come first and word 5 comes last, and leaves every bit value unchanged. When the last bit of word 14 arrives, it reports a 40-bit result with a pass/fail flag through a one-cycle strobe.

A host controller reads the result and uses it to drive recording control. It uses the flag to reject lines that were corrupted in transmission.

Top module: `dlx_extract`

## Requirements
- R1: While reset is high and afterwards until the first completed line, `done` is 0, `cap_ok` is 0 and `cap_data` is all ones.
- R2: A half-bit sample is consumed only in a cycle with `smp_vld` high. Each bit is two consumed samples, first half then second half. First half 1 and second half 0 decode as bit 1, and 0 then 1 decode as bit 0.
- R3: Samples are ignored until `line_start` has been seen. After `line_start` the block searches for the 16-sample biphase image of the parameter `START_CODE` (default 8'h5D), sent MSB first. The bit after the start code's last half-bit is bit 7 of word 3.
- R4: If the start code image is not found within `HUNT_LIMIT` (default 48) consumed samples after `line_start`, the line is dropped. No `done` is raised and the previous result is kept.
- R5: Words are numbered from the start code, which is word 2. Only the bits of words 5, 11, 12, 13 and 14 are stored, MSB first within each word.
- R6: `cap_data[39:32]` holds word 11, `[31:24]` word 12, `[23:16]` word 13, `[15:8]` word 14 and `[7:0]` word 5. Each byte holds its word exactly as decoded, with its first received bit at the byte's MSB.
- R7: A bit whose two halves are equal is a biphase error. If any bit of a stored word has one, `cap_ok` is 0 at `done`, and `cap_data` still carries the decoded bits (the first half's level).
- R8: A biphase error in a word that is not stored (for example word 7 or word 15) leaves `cap_ok` at 1.
- R9: `done` goes high for exactly one cycle: the cycle after the clock edge that consumes the second half of the last bit of word 14.
- R10: A `line_start` during a line aborts the capture in progress and starts a new search. The aborted line never raises `done`, and the next complete line is reported normally.
- R11: `cap_data` and `cap_ok` change only together with a `done` pulse and hold their values in between.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_start | input | 1 | Strobe marking the start of the data line; aborts any line in progress |
| smp_vld | input | 1 | Qualifies `smp` as one half-bit sample |
| smp | input | 1 | Sliced half-bit level |
| done | output | 1 | One-cycle strobe when a line result is written |
| cap_ok | output | 1 | Result had no biphase error in any stored bit |
| cap_data | output | 40 | Stored words, order 11,12,13,14,5 from MSB down |

## Verification
The bench moves the `smp` level during the gap cycles between valid strobes. A decoder that consumes unqualified samples would therefore decode garbage and miss the start code.

It places biphase faults both inside and outside the stored words. One fault sits on the very last half-bit of word 14. A design that drops the final bit's error from the flag would wrongly report that line as good. A design that checks every word would reject lines whose faults lie in words 7 or 15.

A wrong start code, a line aborted halfway through and a line sent with no start strobe must all leave the earlier result untouched and must not raise `done`. The byte order of the result is checked against distinct per-word values, so a design that puts word 5 first, or reverses bits within a byte, shows a mismatch.

// File: rtl/dlx_pkg.sv
package dlx_pkg;

    localparam int WORD_W     = 8;
    localparam int IMG_W      = 2 * WORD_W;
    localparam int KEPT_WORDS = 5;
    localparam int CAP_W      = KEPT_WORDS * WORD_W;
    localparam int WIDX_W     = 4;
    localparam int BIDX_W     = $clog2(WORD_W);

    localparam logic [WIDX_W-1:0] FIRST_DATA_WORD = WIDX_W'(3);
    localparam logic [WIDX_W-1:0] LAST_WORD       = WIDX_W'(14);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HUNT,
        PH_CAPT
    } phase_e;

    typedef struct packed {
        logic vld;
        logic val;
        logic err;
    } bitres_t;

    // Biphase image of a word: bit 1 -> halves 1,0; bit 0 -> halves 0,1.
    // The first transmitted half lands at the image MSB.
    function automatic logic [IMG_W-1:0] bp_image(input logic [WORD_W-1:0] code);
        logic [IMG_W-1:0] img;
        for (int i = 0; i < WORD_W; i++) begin
            img[2*i+1] = code[i];
            img[2*i]   = ~code[i];
        end
        return img;
    endfunction

    function automatic logic word_kept(input logic [WIDX_W-1:0] w);
        return (w == WIDX_W'(5)) || ((w >= WIDX_W'(11)) && (w <= LAST_WORD));
    endfunction

endpackage

// File: rtl/dlx_hunt.sv
module dlx_hunt
    import dlx_pkg::*;
#(
    parameter logic [WORD_W-1:0] START_CODE = 8'h5D,
    parameter int                HUNT_LIMIT = 48
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic smp,
    output logic hit,
    output logic expire
);
    localparam logic [IMG_W-1:0] IMAGE = bp_image(START_CODE);
    localparam int CNT_W = $clog2(HUNT_LIMIT + 1);

    logic [IMG_W-1:0] win;
    logic [IMG_W-1:0] win_nxt;
    logic [CNT_W-1:0] cnt;

    assign win_nxt = {win[IMG_W-2:0], smp};
    assign hit     = en && (win_nxt == IMAGE);
    assign expire  = en && !hit && (cnt == CNT_W'(HUNT_LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            win <= '0;
            cnt <= '0;
        end else if (en) begin
            win <= win_nxt;
            cnt <= cnt + CNT_W'(1);
        end
    end

    AST_HUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt < CNT_W'(HUNT_LIMIT))) else $error("hunt window overrun"); // R4

endmodule

// File: rtl/dlx_bpair.sv
module dlx_bpair
    import dlx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    en,
    input  logic    smp,
    output bitres_t res
);
    logic second;
    logic h1;

    always_comb begin
        res.vld = en && second;
        res.val = h1;
        res.err = (h1 == smp);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            second <= 1'b0;
            h1     <= 1'b0;
        end else if (en) begin
            second <= ~second;
            if (!second) h1 <= smp;
        end
    end

    AST_HALF_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
        (en && !clr) |=> (second != $past(second))) else $error("half phase stuck"); // R2

endmodule

// File: rtl/dlx_collect.sv
module dlx_collect
    import dlx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  bitres_t          bi,
    output logic             last,
    output logic             bad,
    output logic [CAP_W-1:0] cap_img
);
    logic [BIDX_W-1:0] bit_cnt;
    logic [WIDX_W-1:0] word_cnt;
    logic [CAP_W-1:0]  sr;
    logic [CAP_W-1:0]  sr_nxt;
    logic              err_acc;
    logic              kept;
    logic              word_end;

    assign kept     = word_kept(word_cnt);
    assign word_end = (bit_cnt == BIDX_W'(WORD_W - 1));
    assign last     = bi.vld && word_end && (word_cnt == LAST_WORD);
    assign sr_nxt   = (bi.vld && kept) ? {sr[CAP_W-2:0], bi.val} : sr;
    assign bad      = err_acc || (bi.vld && kept && bi.err);
    // arrival order is 5,11,12,13,14; rotating word 5 to the bottom gives 11..14,5
    assign cap_img  = {sr_nxt[CAP_W-WORD_W-1:0], sr_nxt[CAP_W-1 -: WORD_W]};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bit_cnt  <= '0;
            word_cnt <= FIRST_DATA_WORD;
            sr       <= '0;
            err_acc  <= 1'b0;
        end else if (bi.vld) begin
            sr      <= sr_nxt;
            err_acc <= bad;
            bit_cnt <= bit_cnt + BIDX_W'(1);
            if (word_end && (word_cnt != LAST_WORD))
                word_cnt <= word_cnt + WIDX_W'(1);
        end
    end

    AST_WORD_SPAN: assert property (@(posedge clk) disable iff (rst)
        (word_cnt >= FIRST_DATA_WORD) && (word_cnt <= LAST_WORD)) else $error("word index out of line"); // R5

endmodule

// File: rtl/dlx_extract.sv
module dlx_extract
    import dlx_pkg::*;
#(
    parameter logic [WORD_W-1:0] START_CODE = 8'h5D,
    parameter int                HUNT_LIMIT = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_start,
    input  logic             smp_vld,
    input  logic             smp,
    output logic             done,
    output logic             cap_ok,
    output logic [CAP_W-1:0] cap_data
);
    phase_e           st;
    logic             hunt_en;
    logic             capt_en;
    logic             hit;
    logic             expire;
    logic             seq_clr;
    logic             last;
    logic             bad;
    logic [CAP_W-1:0] cap_img;
    bitres_t          bres;

    assign hunt_en = (st == PH_HUNT) && smp_vld && !line_start;
    assign capt_en = (st == PH_CAPT) && smp_vld && !line_start;
    assign seq_clr = line_start || hit;

    dlx_hunt #(
        .START_CODE (START_CODE),
        .HUNT_LIMIT (HUNT_LIMIT)
    ) u_hunt (
        .clk    (clk),
        .rst    (rst),
        .clr    (line_start),
        .en     (hunt_en),
        .smp    (smp),
        .hit    (hit),
        .expire (expire)
    );

    dlx_bpair u_bpair (
        .clk (clk),
        .rst (rst),
        .clr (seq_clr),
        .en  (capt_en),
        .smp (smp),
        .res (bres)
    );

    dlx_collect u_collect (
        .clk     (clk),
        .rst     (rst),
        .clr     (seq_clr),
        .bi      (bres),
        .last    (last),
        .bad     (bad),
        .cap_img (cap_img)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= PH_IDLE;
            done     <= 1'b0;
            cap_ok   <= 1'b0;
            cap_data <= '1;
        end else begin
            done <= 1'b0;
            if (line_start) begin
                st <= PH_HUNT;
            end else begin
                unique case (st)
                    PH_HUNT: begin
                        if (hit)         st <= PH_CAPT;
                        else if (expire) st <= PH_IDLE;
                    end
                    PH_CAPT: begin
                        if (last) begin
                            st       <= PH_IDLE;
                            done     <= 1'b1;
                            cap_ok   <= !bad;
                            cap_data <= cap_img;
                        end
                    end
                    default: st <= PH_IDLE;
                endcase
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than a cycle"); // R9

    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !done) else $error("done after abort"); // R10

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(cap_data)) else $error("result moved without done"); // R11

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(cap_ok)) else $error("flag moved without done"); // R11

endmodule

// File: tb/sim_dlx_extract.sv
module sim_dlx_extract;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_start = 1'b0;
    logic        smp_vld = 1'b0;
    logic        smp = 1'b0;
    logic        done;
    logic        cap_ok;
    logic [39:0] cap_data;

    int n_chk = 0;
    int n_bad = 0;
    int done_cnt = 0;

    always #4 clk = ~clk;

    dlx_extract u0 (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .smp_vld    (smp_vld),
        .smp        (smp),
        .done       (done),
        .cap_ok     (cap_ok),
        .cap_data   (cap_data)
    );

    always @(posedge clk) if (!rst && done) done_cnt <= done_cnt + 1;

    task automatic check(input logic ok, input string req, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] wd(input int seed, input int k);
        return 8'((seed * 37 + k * 29) ^ 8'hA5);
    endfunction

    // one half-bit; the gap cycle carries the opposite level and no strobe
    task automatic half(input logic b);
        @(negedge clk);
        smp_vld = 1'b1;
        smp     = b;
        @(negedge clk);
        smp_vld = 1'b0;
        smp     = ~b;
    endtask

    task automatic send_word(input logic [7:0] w, input int badbit);
        for (int i = 7; i >= 0; i--) begin
            half(w[i]);
            half((i == badbit) ? w[i] : ~w[i]);
        end
    endtask

    task automatic pulse_ls();
        @(negedge clk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    // full line: run-in, start code, words 3..15; one optional faulty bit
    task automatic run_line(input int seed, input logic [7:0] code, input bit do_ls,
                            input int err_word, input int err_bit, input bit expect_done);
        int          d0;
        logic [39:0] exp_data;
        logic [39:0] old_data;
        logic        old_ok;
        logic        exp_ok;
        d0       = done_cnt;
        old_data = cap_data;
        old_ok   = cap_ok;
        if (do_ls) pulse_ls();
        send_word(8'h55, -1);
        send_word(code, -1);
        for (int k = 3; k <= 15; k++) begin
            send_word(wd(seed, k), (k == err_word) ? err_bit : -1);
            if (k == 14) begin
                check(done == expect_done, "R9 done after word 14", 40'(done), 40'(expect_done));
                if (expect_done) begin
                    @(negedge clk);
                    check(done == 1'b0, "R9 done one cycle", 40'(done), 40'd0);
                end
            end
        end
        check(done_cnt - d0 == (expect_done ? 1 : 0), "R9 done count per line",
              40'(done_cnt - d0), 40'(expect_done ? 1 : 0));
        if (expect_done) begin
            exp_data = {wd(seed, 11), wd(seed, 12), wd(seed, 13), wd(seed, 14), wd(seed, 5)};
            exp_ok   = !(err_word == 5 || (err_word >= 11 && err_word <= 14));
            check(cap_data == exp_data, "R6 R5 R2 word order and values", cap_data, exp_data);
            check(cap_ok == exp_ok, "R7 R8 validity flag", 40'(cap_ok), 40'(exp_ok));
        end else begin
            check(cap_data == old_data, "R4 R3 result kept", cap_data, old_data);
            check(cap_ok == old_ok, "R4 R3 flag kept", 40'(cap_ok), 40'(old_ok));
        end
    endtask

    task automatic t_reset();
        check(done == 1'b0, "R1 done in reset", 40'(done), 40'd0);
        check(cap_ok == 1'b0, "R1 ok in reset", 40'(cap_ok), 40'd0);
        check(cap_data == '1, "R1 data in reset", cap_data, '1);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(cap_data == '1 && done == 1'b0, "R1 after reset", cap_data, '1);
    endtask

    task automatic t_no_strobe();   // R3
        run_line(3, 8'h5D, 1'b0, 0, -1, 1'b0);
    endtask

    task automatic t_clean();       // R2 R5 R6 R9
        run_line(1, 8'h5D, 1'b1, 0, -1, 1'b1);
        run_line(2, 8'h5D, 1'b1, 0, -1, 1'b1);
    endtask

    task automatic t_err_kept();    // R7
        run_line(4, 8'h5D, 1'b1, 12, 3, 1'b1);
        run_line(5, 8'h5D, 1'b1, 14, 0, 1'b1);
        run_line(6, 8'h5D, 1'b1, 5, 7, 1'b1);
    endtask

    task automatic t_err_skip();    // R8
        run_line(7, 8'h5D, 1'b1, 7, 2, 1'b1);
        run_line(8, 8'h5D, 1'b1, 15, 0, 1'b1);
    endtask

    task automatic t_bad_code();    // R4
        run_line(9, 8'h5C, 1'b1, 0, -1, 1'b0);
    endtask

    task automatic t_abort();       // R10
        int d0;
        d0 = done_cnt;
        pulse_ls();
        send_word(8'h55, -1);
        send_word(8'h5D, -1);
        for (int k = 3; k <= 12; k++) send_word(wd(11, k), -1);
        run_line(12, 8'h5D, 1'b1, 0, -1, 1'b1);
        check(done_cnt - d0 == 1, "R10 aborted line silent", 40'(done_cnt - d0), 40'd1);
    endtask

    task automatic t_hold();        // R11
        logic [39:0] keep;
        keep = cap_data;
        for (int i = 0; i < 30; i++) half(i[0]);
        repeat (10) @(negedge clk);
        check(cap_data == keep && done == 1'b0, "R11 result held", cap_data, keep);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_no_strobe();
        t_clean();
        t_err_kept();
        t_err_skip();
        t_bad_code();
        t_abort();
        t_hold();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule